// File: doc/BRIEF.md
# Timer Capture / Compare / PWM Channel

This block is one channel of a general-purpose timer. A free-running up-counter with a programmable modulo lives outside the block. Its current value and a one-cycle overflow strobe arrive as inputs, and the strobe is high in the cycle where the counter has just wrapped to zero. A two-bit mode field and a two-bit edge/level field choose one of four roles: output preset, input capture, unbuffered output compare or PWM, and buffered output compare or PWM. A toggle-on-overflow bit and a maximum-duty bit refine the output roles.

In capture, the input pin passes through a two-flop synchronizer. A qualifying edge latches the counter into the channel register and raises the channel flag. In the output roles, a match between the counter and the active compare value toggles, clears or sets the output pin and raises the flag. With toggle-on-overflow set, the pin also toggles at each overflow, which gives a PWM waveform whose duty is set by the compare value. The buffered role stages compare writes in a shadow register and applies them only at overflow, so a period is never cut short. The flag stays set until a clear strobe. All control inputs are plain levels or pulses; the block has no streaming interface and no back-pressure.

Top module: `tmr_chan`

## Requirements
- R1: After reset, pin_out is 1, pin_oe is 0, chan_flag is 0 and chan_val is 0.
- R2: Whenever edge_sel is 00 (preset), pin_oe is 0 and pin_out takes the value NOT mode_sel[0] from the next cycle on (mode_sel[0]=0 gives high, 1 gives low).
- R3: With mode_sel 00 and edge_sel not 00 (capture), edge_sel 01 accepts rising edges, 10 falling edges and 11 both. Edges are found on the pin after a two-flop synchronizer. An accepted edge copies cnt_val into chan_val and sets chan_flag at the next clock edge.
- R4: An edge detected while the channel has been in capture for fewer than two clocks is ignored: chan_flag and chan_val do not change.
- R5: With mode_sel 01 and edge_sel not 00, the first cycle in which cnt_val equals chan_val is a match. A match applies the action of edge_sel (01 toggle, 10 drive 0, 11 drive 1) and sets chan_flag. In this role and in preset, a cmp_we write goes straight into chan_val.
- R6: With mode_sel 1x and edge_sel not 00 (buffered), a cmp_we write goes to a shadow register. The shadow is copied into chan_val only in a cycle where cnt_ovf is high. Match actions are the same as in R5.
- R7: In the output roles, tog_ovf=1 toggles pin_out in each cnt_ovf cycle. In capture, tog_ovf has no effect and pin_out holds its value.
- R8: When cnt_ovf and a match occur in the same cycle with tog_ovf=1, only the overflow action is applied to pin_out.
- R9: max_duty AND tog_ovf is sampled at each cnt_ovf. While the sampled value is 1, the overflow drives pin_out to the active level (0 when edge_sel is 11, otherwise 1), and matches leave the pin unchanged for that whole period.
- R10: chan_flag is cleared by a flag_clr pulse. A set in the same cycle wins over the clear.
- R11: pin_oe is 1 exactly when mode_sel is not 00 and edge_sel is not 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_ovf | input | 1 | Counter overflow strobe, high in the first cycle after the wrap |
| mode_sel | input | 2 | Channel role select |
| edge_sel | input | 2 | Capture edge or compare pin action |
| tog_ovf | input | 1 | Toggle the pin at each overflow |
| max_duty | input | 1 | Force 100% duty (requires tog_ovf) |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value to write |
| flag_clr | input | 1 | Clear strobe for the channel flag |
| pin_in | input | 1 | Asynchronous channel input pin |
| pin_out | output | 1 | Channel output level |
| pin_oe | output | 1 | High when the channel drives the pin |
| chan_flag | output | 1 | Capture or match flag |
| chan_val | output | CNT_W | Channel register: captured value or active compare value |

## Verification
A wrong compare register or a missed shadow transfer shows as a pin edge at the wrong counter value, at the latest one counter period after the fault. A bad synchronizer tap or guard count shows as a flag and captured value that appear a cycle early or late, or that do not appear at all. A stale max-duty latch keeps the pin at its active level, or releases it, one whole period away from the point where it should change. Because the bench compares all four outputs on every clock, each of these faults is reported in the cycle where the pin first differs.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [1:0] {
    CH_PRESET  = 2'd0,
    CH_CAPTURE = 2'd1,
    CH_CMP     = 2'd2,
    CH_BUFCMP  = 2'd3
  } ch_kind_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } ch_act_e;

  typedef struct packed {
    ch_kind_e kind;
    logic     drive;
    logic     preset_lvl;
    ch_act_e  act;
    logic     cap_rise;
    logic     cap_fall;
  } ch_cfg_t;

  function automatic ch_cfg_t decode_cfg(input logic [1:0] msel, input logic [1:0] esel);
    ch_cfg_t c;
    c.preset_lvl = ~msel[0];
    c.act        = ch_act_e'(esel);
    c.cap_rise   = 1'b0;
    c.cap_fall   = 1'b0;
    c.drive      = 1'b0;
    if (esel == 2'b00) begin
      c.kind = CH_PRESET;
    end else if (msel == 2'b00) begin
      c.kind     = CH_CAPTURE;
      c.cap_rise = esel[0];
      c.cap_fall = esel[1];
    end else if (msel[1]) begin
      c.kind  = CH_BUFCMP;
      c.drive = 1'b1;
    end else begin
      c.kind  = CH_CMP;
      c.drive = 1'b1;
    end
    return c;
  endfunction

endpackage

// File: rtl/tmr_chan_decode.sv
module tmr_chan_decode
  import tmr_chan_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic [1:0] edge_sel,
  output ch_cfg_t    cfg
);

  always_comb begin
    cfg = decode_cfg(mode_sel, edge_sel);
  end

  // R11
  drive_mode_chk: assert final (cfg.drive == ((mode_sel != 2'b00) && (edge_sel != 2'b00)));

endmodule

// File: rtl/tmr_chan_capture.sv
module tmr_chan_capture #(
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_CYC   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic rise_en,
  input  logic fall_en,
  input  logic pin_in,
  output logic cap_evt
);

  localparam int GW = $clog2(GUARD_CYC + 2);
  localparam logic [GW-1:0] GUARD_LIM = GW'(GUARD_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [GW-1:0]          guard_q;
  logic                   cur_s;
  logic                   rise_w;
  logic                   fall_w;
  logic                   armed_w;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  assign cur_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 guard_q <= '0;
    else if (!enable)           guard_q <= '0;
    else if (guard_q < GUARD_LIM) guard_q <= guard_q + 1'b1;
  end

  assign rise_w  = cur_s & ~prev_q;
  assign fall_w  = ~cur_s & prev_q;
  assign armed_w = enable && (guard_q == GUARD_LIM);
  assign cap_evt = armed_w && ((rise_en && rise_w) || (fall_en && fall_w));

  // R4
  guard_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> !cap_evt);

  // R4
  guard_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> !cap_evt);

  // R3
  cap_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> enable && (rise_w || fall_w));

endmodule

// File: rtl/tmr_chan_cmpreg.sv
module tmr_chan_cmpreg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buffered,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             load_ovf,
  input  logic             cap_evt,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [CNT_W-1:0] act_q,
  output logic             match_raw
);

  logic [CNT_W-1:0] shd_q;
  logic             eq_q;
  logic             eq_w;

  assign eq_w      = (cnt_val == act_q);
  assign match_raw = eq_w & ~eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      shd_q <= '0;
    end else if (cap_evt) begin
      act_q <= cnt_val;
    end else if (buffered) begin
      if (load_ovf) act_q <= shd_q;
      if (wr_en)    shd_q <= wr_data;
    end else if (wr_en) begin
      act_q <= wr_data;
      shd_q <= wr_data;
    end
  end

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buffered && !load_ovf |=> $stable(act_q));

  // R5
  match_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_raw && $stable(cnt_val) |=> !match_raw);

endmodule

// File: rtl/tmr_chan_pinout.sv
module tmr_chan_pinout
  import tmr_chan_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ch_cfg_t cfg,
  input  logic    cnt_ovf,
  input  logic    tog_ovf,
  input  logic    max_duty,
  input  logic    match,
  output logic    pin_q
);

  logic max_q;
  logic max_nxt;
  logic act_lvl;
  logic pin_nxt;

  assign max_nxt = cnt_ovf ? (max_duty & tog_ovf) : max_q;
  assign act_lvl = (cfg.act != ACT_SET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) max_q <= 1'b0;
    else        max_q <= max_nxt;
  end

  always_comb begin
    pin_nxt = pin_q;
    if (cfg.kind == CH_PRESET) begin
      pin_nxt = cfg.preset_lvl;
    end else if (cfg.drive) begin
      if (cnt_ovf && tog_ovf) begin
        pin_nxt = max_nxt ? act_lvl : ~pin_q;
      end else if (match && !max_q) begin
        unique case (cfg.act)
          ACT_TOGGLE: pin_nxt = ~pin_q;
          ACT_CLEAR:  pin_nxt = 1'b0;
          ACT_SET:    pin_nxt = 1'b1;
          default:    pin_nxt = pin_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= pin_nxt;
  end

  // R7
  cap_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.kind == CH_CAPTURE |=> $stable(pin_q));

  // R8
  ovf_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.drive && cnt_ovf && tog_ovf && !max_duty |=> pin_q != $past(pin_q));

  // R9
  max_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.drive && max_q && !cnt_ovf |=> $stable(pin_q));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_CYC   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_ovf,
  input  logic [1:0]       mode_sel,
  input  logic [1:0]       edge_sel,
  input  logic             tog_ovf,
  input  logic             max_duty,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             flag_clr,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             chan_flag,
  output logic [CNT_W-1:0] chan_val
);

  ch_cfg_t cfg;
  logic    cap_evt;
  logic    match_raw;
  logic    match_evt;
  logic    flag_q;

  tmr_chan_decode u_decode (
    .mode_sel (mode_sel),
    .edge_sel (edge_sel),
    .cfg      (cfg)
  );

  tmr_chan_capture #(
    .SYNC_STAGES (SYNC_STAGES),
    .GUARD_CYC   (GUARD_CYC)
  ) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (cfg.kind == CH_CAPTURE),
    .rise_en (cfg.cap_rise),
    .fall_en (cfg.cap_fall),
    .pin_in  (pin_in),
    .cap_evt (cap_evt)
  );

  tmr_chan_cmpreg #(
    .CNT_W (CNT_W)
  ) u_cmpreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .buffered  (cfg.kind == CH_BUFCMP),
    .wr_en     (cmp_we),
    .wr_data   (cmp_wdata),
    .load_ovf  (cnt_ovf),
    .cap_evt   (cap_evt),
    .cnt_val   (cnt_val),
    .act_q     (chan_val),
    .match_raw (match_raw)
  );

  assign match_evt = cfg.drive & match_raw;

  tmr_chan_pinout u_pinout (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .cnt_ovf  (cnt_ovf),
    .tog_ovf  (tog_ovf),
    .max_duty (max_duty),
    .match    (match_evt),
    .pin_q    (pin_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    flag_q <= 1'b0;
    else if (match_evt || cap_evt) flag_q <= 1'b1;
    else if (flag_clr)             flag_q <= 1'b0;
  end

  assign chan_flag = flag_q;
  assign pin_oe    = cfg.drive;

  // R10
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_flag ##1 chan_flag |-> $past(match_evt || cap_evt));

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !match_evt && !cap_evt |=> !chan_flag);

  // R3
  cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> chan_val == $past(cnt_val) && chan_flag);

endmodule

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;

  localparam int W   = 16;
  localparam int MOD = 19;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic         cnt_ovf = 1'b0;
  logic [1:0]   msel = 2'b00;
  logic [1:0]   esel = 2'b00;
  logic         tog = 1'b0;
  logic         maxd = 1'b0;
  logic         we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic         fclr = 1'b0;
  logic         pin_in = 1'b0;
  logic         pin_out, pin_oe, chan_flag;
  logic [W-1:0] chan_val;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string req = "R1";

  always #4 clk = ~clk;

  tmr_chan #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
    .mode_sel(msel), .edge_sel(esel), .tog_ovf(tog), .max_duty(maxd),
    .cmp_we(we), .cmp_wdata(wdata), .flag_clr(fclr), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .chan_flag(chan_flag), .chan_val(chan_val)
  );

  // free-running counter with modulo, overflow strobe in the cycle at zero after a wrap
  always @(posedge clk) begin
    if (!rst_n) begin
      cnt_val <= '0;
      cnt_ovf <= 1'b0;
    end else begin
      cnt_val <= (cnt_val == MOD) ? '0 : cnt_val + 1'b1;
      cnt_ovf <= (cnt_val == MOD);
    end
  end

  // reference model state
  bit         m_out = 1, m_flag = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0, m_eq = 0, m_max = 0;
  int         m_g = 0;
  bit [W-1:0] m_act = 0, m_shd = 0;
  bit         outm, capm, bufm, mt, cp, nmax, alvl, ok_edge, exp_oe;

  task automatic check(input string r, input bit cond, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_out = 1; m_flag = 0; m_act = 0; m_shd = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_g = 0; m_eq = 0; m_max = 0;
    end else begin
      outm = (msel != 2'b00) && (esel != 2'b00);
      capm = (msel == 2'b00) && (esel != 2'b00);
      bufm = msel[1] && (esel != 2'b00);
      mt   = outm && (cnt_val == m_act) && !m_eq;
      ok_edge = (esel[0] && m_s2 && !m_s3) || (esel[1] && !m_s2 && m_s3);
      cp   = capm && (m_g >= 2) && ok_edge;
      nmax = cnt_ovf ? (maxd && tog) : m_max;
      alvl = (esel != 2'b11);
      m_eq = (cnt_val == m_act);
      if (esel == 2'b00) m_out = !msel[0];
      else if (outm) begin
        if (cnt_ovf && tog) m_out = nmax ? alvl : !m_out;
        else if (mt && !m_max) begin
          if (esel == 2'b01) m_out = !m_out;
          else m_out = (esel == 2'b11);
        end
      end
      m_max = nmax;
      if (mt || cp) m_flag = 1; else if (fclr) m_flag = 0;
      if (cp) m_act = cnt_val;
      else if (bufm) begin
        if (cnt_ovf) m_act = m_shd;
        if (we) m_shd = wdata;
      end else if (we) begin
        m_act = wdata; m_shd = wdata;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      if (!capm) m_g = 0; else if (m_g < 2) m_g++;
    end
    #2;
    if (rst_n) begin
      exp_oe = (msel != 2'b00) && (esel != 2'b00);
      check(req, pin_out == m_out, "pin_out", pin_out, m_out);
      check((esel == 2'b00) ? "R2" : "R11", pin_oe == exp_oe, "pin_oe", pin_oe, exp_oe);
      check(req, chan_flag == m_flag, "chan_flag", chan_flag, m_flag);
      check(req, chan_val == m_act, "chan_val", chan_val, m_act);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setcfg(input logic [1:0] m, input logic [1:0] e, input logic t, input logic x);
    @(negedge clk);
    msel = m; esel = e; tog = t; maxd = x;
  endtask

  task automatic wrcmp(input logic [W-1:0] v);
    @(negedge clk);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic clrflag();
    @(negedge clk);
    fclr = 1'b1;
    @(negedge clk);
    fclr = 1'b0;
  endtask

  task automatic pulse_pin(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pin_in = ~pin_in;
      wait_n(gap);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    @(negedge clk);
    req = "R1";
    check("R1", pin_out == 1'b1, "pin_out", pin_out, 1);
    check("R1", pin_oe == 1'b0, "pin_oe", pin_oe, 0);
    check("R1", chan_flag == 1'b0, "chan_flag", chan_flag, 0);
    check("R1", chan_val == '0, "chan_val", chan_val, 0);

    req = "R2";
    setcfg(2'b01, 2'b00, 1'b0, 1'b0); wait_n(5);
    check("R2", pin_out == 1'b0 && pin_oe == 1'b0, "preset low", pin_out, 0);
    setcfg(2'b10, 2'b00, 1'b0, 1'b0); wait_n(5);
    check("R2", pin_out == 1'b1, "preset high", pin_out, 1);

    req = "R5";
    wrcmp(16'd6);
    setcfg(2'b01, 2'b01, 1'b0, 1'b0); wait_n(45);
    setcfg(2'b01, 2'b10, 1'b0, 1'b0); wait_n(25);
    setcfg(2'b01, 2'b11, 1'b0, 1'b0); wait_n(25);
    wrcmp(16'd12); wait_n(25);

    req = "R7";
    setcfg(2'b01, 2'b10, 1'b1, 1'b0); wait_n(50);
    req = "R10";
    clrflag(); wait_n(3);
    clrflag(); wait_n(20);

    req = "R8";
    wrcmp(16'd0); wait_n(45);
    setcfg(2'b01, 2'b11, 1'b1, 1'b0); wait_n(45);

    req = "R9";
    wrcmp(16'd8);
    setcfg(2'b01, 2'b10, 1'b1, 1'b1); wait_n(50);
    setcfg(2'b01, 2'b10, 1'b1, 1'b0); wait_n(50);
    setcfg(2'b01, 2'b11, 1'b1, 1'b1); wait_n(50);
    setcfg(2'b01, 2'b11, 1'b0, 1'b1); wait_n(30);

    req = "R6";
    setcfg(2'b10, 2'b10, 1'b1, 1'b0); wait_n(7);
    wrcmp(16'd4); wait_n(30);
    wrcmp(16'd15); wait_n(3);
    wrcmp(16'd11); wait_n(40);
    setcfg(2'b11, 2'b01, 1'b1, 1'b0);
    wrcmp(16'd3); wait_n(45);

    req = "R3";
    setcfg(2'b00, 2'b01, 1'b0, 1'b0); clrflag(); wait_n(4);
    pulse_pin(6, 7);
    setcfg(2'b00, 2'b10, 1'b0, 1'b0); wait_n(4);
    pulse_pin(6, 5);
    setcfg(2'b00, 2'b11, 1'b0, 1'b0); wait_n(4);
    pulse_pin(6, 9);

    req = "R7";
    setcfg(2'b00, 2'b11, 1'b1, 1'b0); wait_n(2);
    begin
      logic held;
      held = pin_out;
      wait_n(45);
      check("R7", pin_out == held, "capture pin", pin_out, held);
    end

    req = "R4";
    setcfg(2'b01, 2'b10, 1'b0, 1'b0);
    pin_in = 1'b0;
    wait_n(10);
    clrflag();
    pin_in = 1'b1;
    @(negedge clk);
    msel = 2'b00; esel = 2'b01; fclr = 1'b1;
    begin
      logic [W-1:0] v0;
      v0 = chan_val;
      @(negedge clk);
      fclr = 1'b0;
      wait_n(6);
      check("R4", chan_flag == 1'b0, "guard flag", chan_flag, 0);
      check("R4", chan_val == v0, "guard value", chan_val, v0);
    end
    pulse_pin(4, 6);

    wait_n(5);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, actual=running expected=done");
    finish_run();
  end

endmodule